// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each serial frame into an 8-bit scan code for on-chip logic. Both lines are open-collector and idle high. The keyboard clock is much slower than the system clock. Both lines are first brought into the system clock domain, then cleaned of short glitches. Each bit is taken on a falling edge of the cleaned keyboard clock.

A frame starts with a low start bit. Eight data bits follow, least significant first. Then come an odd parity bit and a high stop bit. When a good frame completes, the byte is placed on the code output and an arrival flag is raised. The arrival flag stays high until the host pulses the acknowledge input.

An error flag reports three faults: a parity fault, a stop-bit fault, and an overflow, which is a second good frame arriving before the first was read. The error flag clears by itself when the next start bit is seen. If a frame stalls part-way through, a timeout drops the partial frame and the receiver returns to idle.

Top module: `kbd_frame_rx`

## Requirements
- R1: While and after reset, `code_o` is 0, `code_vld_o` is 0 and `code_err_o` is 0. Reset is asynchronous and active low.
- R2: A frame is eleven bits in this order:
  - a start bit of 0;
  - eight data bits, least significant bit first;
  - a parity bit chosen so that the data bits plus the parity bit hold an odd number of ones;
  - a stop bit of 1.

  When a good frame completes and no code is waiting unread, `code_o` takes the data byte and `code_vld_o` goes to 1.
- R3: Bits are sampled on falling edges of the filtered keyboard clock. A low pulse on the keyboard clock that lasts fewer than `FILT_LEN` system clock cycles is ignored. It does not start a frame and does not clear the error flag.
- R4: `code_vld_o` stays at 1 until `rd_ack_i` is high at a rising clock edge. It reads 0 in the cycle that follows that edge.
- R5: If the data bits plus the parity bit hold an even number of ones, `code_err_o` goes to 1. `code_o` and `code_vld_o` are left unchanged.
- R6: If the stop bit is 0, `code_err_o` goes to 1. `code_o` and `code_vld_o` are left unchanged.
- R7: Overflow is a good frame that completes while `code_vld_o` is 1 and `rd_ack_i` is low. On overflow, `code_err_o` goes to 1, `code_o` keeps the unread earlier code, and `code_vld_o` stays at 1.
- R8: `code_err_o` returns to 0 when a start bit is detected.
- R9: While the receiver is idle, a falling keyboard-clock edge with data high is not treated as a start bit. It leaves every output unchanged.
- R10: During a frame, if no falling edge arrives for `TIMEOUT_CYC` system cycles, the partial frame is discarded and the receiver goes back to idle. No output changes, and the next full frame is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line (open-collector, idles high) |
| ps2_dat_i | input | 1 | Keyboard data line (open-collector, idles high) |
| rd_ack_i | input | 1 | Host pulse confirming the current code was read |
| code_o | output | 8 | Most recently accepted scan code |
| code_vld_o | output | 1 | Sticky flag: an unread code is waiting |
| code_err_o | output | 1 | Parity, stop-bit or overflow fault since the last start bit |

## Verification
The hardest case to reach is proving that something did not happen on the keyboard clock. A glitch or a high-data falling edge that was wrongly taken as a start bit would not show up directly at the ports.

The stimulus therefore sends these disturbances while the error flag is known to be set, after a deliberate stop-bit fault. A false start would clear the error flag, and it would also misalign the next frame; both show up at the ports.

The timeout case is handled the same way. A partial frame is left hanging past the limit, and then a full frame must decode correctly.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
   localparam int KBD_DATA_W = 8;
   localparam int KBD_TAIL_W = 2;                       // parity + stop
   localparam int KBD_BODY_W = KBD_DATA_W + KBD_TAIL_W; // bits after start

   typedef enum logic [0:0] {
      RX_IDLE = 1'b0,
      RX_BITS = 1'b1
   } rx_state_e;

   typedef struct packed {
      logic [KBD_DATA_W-1:0] data;
      logic                  par_ok;
      logic                  stop_ok;
   } rx_frame_t;
endpackage

// File: rtl/kbd_line_filt.sv
module kbd_line_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("kbd_line_filt: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("kbd_line_filt: FILT_LEN must not be negative");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign raw = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 0) begin : g_nofilt
      assign line_o = raw;
   end else begin : g_filt
      localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
      logic [CW-1:0] run_q;
      logic          lvl_q;

      // level follows raw only after FILT_LEN consecutive differing cycles
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
            lvl_q <= 1'b1;
         end else if (raw == lvl_q) begin
            run_q <= '0;
         end else if (run_q == CW'(FILT_LEN-1)) begin
            run_q <= '0;
            lvl_q <= raw;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
      assign line_o = lvl_q;
   end
endmodule

// File: rtl/kbd_bit_shifter.sv
module kbd_bit_shifter
   import kbd_rx_pkg::*;
#(
   parameter int TIMEOUT_CYC = 125000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      kclk_i,
   input  logic      kdat_i,
   output logic      start_o,
   output logic      done_o,
   output rx_frame_t frame_o
);
   if (TIMEOUT_CYC < 16) begin : g_bad_to
      $error("kbd_bit_shifter: TIMEOUT_CYC too small");
   end

   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam int IW = $clog2(KBD_BODY_W + 1);

   rx_state_e             state_q;
   logic                  kclk_q;
   logic                  fall;
   logic [IW-1:0]         idx_q;
   logic [KBD_BODY_W-1:0] shf_q;
   logic [KBD_BODY_W-1:0] shf_nx;
   logic [TW-1:0]         idle_q;

   assign fall   = kclk_q & ~kclk_i;
   assign shf_nx = {kdat_i, shf_q[KBD_BODY_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         kclk_q  <= 1'b1;
         idx_q   <= '0;
         shf_q   <= '0;
         idle_q  <= '0;
         start_o <= 1'b0;
         done_o  <= 1'b0;
         frame_o <= '0;
      end else begin
         kclk_q  <= kclk_i;
         start_o <= 1'b0;
         done_o  <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               idle_q <= '0;
               idx_q  <= '0;
               if (fall && !kdat_i) begin
                  state_q <= RX_BITS;
                  start_o <= 1'b1;
               end
            end
            RX_BITS: begin
               if (fall) begin
                  idle_q <= '0;
                  shf_q  <= shf_nx;
                  idx_q  <= idx_q + 1'b1;
                  if (idx_q == IW'(KBD_BODY_W-1)) begin
                     state_q         <= RX_IDLE;
                     done_o          <= 1'b1;
                     frame_o.data    <= shf_nx[KBD_DATA_W-1:0];
                     frame_o.par_ok  <= ^shf_nx[KBD_DATA_W:0];
                     frame_o.stop_ok <= shf_nx[KBD_BODY_W-1];
                  end
               end else if (idle_q == TW'(TIMEOUT_CYC-1)) begin
                  state_q <= RX_IDLE;
               end else begin
                  idle_q <= idle_q + 1'b1;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/kbd_flag_ctl.sv
module kbd_flag_ctl
   import kbd_rx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  done_i,
   input  rx_frame_t             frame_i,
   input  logic                  rd_ack_i,
   output logic [KBD_DATA_W-1:0] code_o,
   output logic                  vld_o,
   output logic                  err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         vld_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         if (start_i)  err_o <= 1'b0;
         if (rd_ack_i) vld_o <= 1'b0;
         if (done_i) begin
            if (!(frame_i.par_ok && frame_i.stop_ok)) begin
               err_o <= 1'b1;
            end else if (vld_o && !rd_ack_i) begin
               err_o <= 1'b1;
            end else begin
               code_o <= frame_i.data;
               vld_o  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
   import kbd_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int TIMEOUT_CYC = 125000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ps2_clk_i,
   input  logic                  ps2_dat_i,
   input  logic                  rd_ack_i,
   output logic [KBD_DATA_W-1:0] code_o,
   output logic                  code_vld_o,
   output logic                  code_err_o
);
   logic      kclk_f;
   logic      kdat_f;
   logic      start_p;
   logic      done_p;
   logic      good_p;
   rx_frame_t rx_frame;

   kbd_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_clk_filt (
      .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .line_o(kclk_f)
   );

   kbd_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dat_filt (
      .clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i), .line_o(kdat_f)
   );

   kbd_bit_shifter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_shift (
      .clk(clk), .rst_n(rst_n), .kclk_i(kclk_f), .kdat_i(kdat_f),
      .start_o(start_p), .done_o(done_p), .frame_o(rx_frame)
   );

   kbd_flag_ctl u_flags (
      .clk(clk), .rst_n(rst_n), .start_i(start_p), .done_i(done_p),
      .frame_i(rx_frame), .rd_ack_i(rd_ack_i),
      .code_o(code_o), .vld_o(code_vld_o), .err_o(code_err_o)
   );

   assign good_p = done_p && rx_frame.par_ok && rx_frame.stop_ok;
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_ack_i,
   input logic [7:0] code_o,
   input logic       vld,
   input logic       err,
   input logic       start_p,
   input logic       done_p,
   input logic       good_p
);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (good_p && !vld) |=> vld);

   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && rd_ack_i && !done_p) |=> !vld);

   p_vld_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !rd_ack_i) |=> vld);

   p_bad_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_p && !good_p && !rd_ack_i) |=> (err && $stable(code_o) && $stable(vld)));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (good_p && vld && !rd_ack_i) |=> (err && $stable(code_o) && vld));

   p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !err);

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(done_p));

   p_vld_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld) |-> $past(good_p));

   p_start_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_p && done_p));
endmodule

bind kbd_frame_rx kbd_frame_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_ack_i(rd_ack_i), .code_o(code_o),
   .vld(code_vld_o), .err(code_err_o), .start_p(start_p),
   .done_p(done_p), .good_p(good_p)
);

// File: tb/sim_kbd_frame_rx.sv
module sim_kbd_frame_rx;
   localparam int HP  = 12;   // keyboard clock phase, in system cycles
   localparam int TMO = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ps2_clk = 1'b1;
   logic       ps2_dat = 1'b1;
   logic       rd_ack = 1'b0;
   logic [7:0] code;
   logic       vld;
   logic       err;
   int         n_chk = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   kbd_frame_rx #(.SYNC_STAGES(2), .FILT_LEN(3), .TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
      .rd_ack_i(rd_ack), .code_o(code), .code_vld_o(vld), .code_err_o(err)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [10:0] mk_frame(input logic [7:0] d, input logic flip_par,
                                            input logic stop);
      return {stop, (~^d) ^ flip_par, d, 1'b0};
   endfunction

   task automatic send_bits(input logic [10:0] fr, input int n);
      for (int i = 0; i < n; i++) begin
         ps2_dat = fr[i];
         wait_cyc(HP/2);
         ps2_clk = 1'b0;
         wait_cyc(HP);
         ps2_clk = 1'b1;
         wait_cyc(HP/2);
      end
      ps2_dat = 1'b1;
   endtask

   task automatic send_frame(input logic [10:0] fr);
      send_bits(fr, 11);
      wait_cyc(20);
   endtask

   task automatic ack();
      @(negedge clk) rd_ack = 1'b1;
      @(negedge clk) rd_ack = 1'b0;
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      report();
      $finish;
   end

   initial begin
      wait_cyc(5);
      chk("R1 code in reset", code, 0);
      chk("R1 vld in reset", vld, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk("R1 code", code, 0);
      chk("R1 vld", vld, 0);
      chk("R1 err", err, 0);

      // R2/R4: every byte value, read back after each frame
      for (int d = 0; d < 256; d++) begin
         send_frame(mk_frame(8'(d), 1'b0, 1'b1));
         chk("R2 code", code, 32'(d));
         chk("R2 vld", vld, 1);
         chk("R2 err", err, 0);
         if (d == 8'hA5) begin
            wait_cyc(100);
            chk("R4 vld held", vld, 1);
         end
         ack();
         chk("R4 vld dropped", vld, 0);
      end

      // R5: bad parity
      send_frame(mk_frame(8'h3C, 1'b1, 1'b1));
      chk("R5 err", err, 1);
      chk("R5 vld", vld, 0);
      chk("R5 code", code, 8'hFF);

      // R6: bad stop
      send_frame(mk_frame(8'h56, 1'b0, 1'b0));
      chk("R6 err", err, 1);
      chk("R6 vld", vld, 0);
      chk("R6 code", code, 8'hFF);

      // R3: short clock glitches with data low must not start a frame
      ps2_dat = 1'b0;
      for (int g = 0; g < 4; g++) begin
         ps2_clk = 1'b0;
         wait_cyc(2);
         ps2_clk = 1'b1;
         wait_cyc(20);
      end
      ps2_dat = 1'b1;
      wait_cyc(10);
      chk("R3 glitch err kept", err, 1);

      // R9: falling edges with data high while idle
      send_bits(11'h7FF, 3);
      wait_cyc(10);
      chk("R9 err kept", err, 1);
      chk("R9 vld", vld, 0);

      // R8: err clears at start bit; R3 alignment afterwards
      send_bits(mk_frame(8'h12, 1'b0, 1'b1), 1);
      chk("R8 err cleared", err, 0);
      send_bits(mk_frame(8'h12, 1'b0, 1'b1) >> 1, 10);
      wait_cyc(20);
      chk("R3 code", code, 8'h12);
      chk("R3 vld", vld, 1);

      // R7: overflow
      send_frame(mk_frame(8'h34, 1'b0, 1'b1));
      chk("R7 err", err, 1);
      chk("R7 code kept", code, 8'h12);
      chk("R7 vld", vld, 1);
      ack();

      // R10: stalled frame
      send_bits(mk_frame(8'h78, 1'b0, 1'b1), 5);
      wait_cyc(TMO + 100);
      chk("R10 vld", vld, 0);
      chk("R10 code", code, 8'h12);
      send_frame(mk_frame(8'h9A, 1'b0, 1'b1));
      chk("R10 code after", code, 8'h9A);
      chk("R10 vld after", vld, 1);
      chk("R10 err after", err, 0);

      report();
      $finish;
   end
endmodule